// File: doc/BRIEF.md
# Tag-Based Reservation Station Array

This block is the waiting room between an in-order instruction queue and the floating-point functional units. Each accepted instruction takes a free station of its class (add class or multiply class). From then on it no longer refers to architectural register names. Each source operand is held either as a value or as the tag of the station that will produce it. A register result-status table tells, for every architectural register, which station (if any) will write it next. A register value table holds the committed values.

Producers return results on one shared broadcast bus: a valid bit, a 4-bit source tag and 64 bits of data. Every waiting station compares its pending tags with the bus tag and picks up the data on a match. The register tables accept the data only when the register's recorded producer tag equals the bus tag. The station whose tag is on the bus is released.

A station whose operands are both present is handed to the functional-unit port. At most one station is handed over per cycle, and the lowest-indexed one goes first. The functional units themselves live outside the block. They return results on the bus with the station's tag.

Top module: `rs_array`

## Requirements
- R1: `issue_ready` is high exactly when a station of the class picked by `issue_op[1]` is free: 0 selects the add class, 1 the multiply class. An instruction is accepted only in a cycle with `issue_valid` and `issue_ready` both high; otherwise it stalls and changes nothing.
- R2: Stations are numbered from 0. Station i carries tag i+1, and tag 0 means "no pending producer". With NADD=2 and NMUL=2, the add class holds tags 1 and 2 and the multiply class holds tags 3 and 4. An accepted instruction takes the lowest-numbered free station of its class.
- R3: At issue, a source whose register has status tag 0 takes the register value. A source whose status tag equals the tag broadcast in that same cycle takes the bus data. Any other source waits on the recorded tag.
- R4: A busy station waiting on a tag that appears on the bus captures the bus data into that operand and stops waiting on it.
- R5: A station is presented on the dispatch port only when it is busy, both operands are present and it has not been dispatched before. `disp_tag`, `disp_op`, `disp_vj` and `disp_vk` then show its tag, opcode and operand values. Dispatch becomes visible in the cycle after the last operand arrives.
- R6: At most one station is dispatched per cycle. Among ready stations, the one with the lowest tag goes first.
- R7: After an accepted issue, the register read port shows the new station's tag as the destination's status, replacing any older tag.
- R8: A broadcast writes a register's value and clears its status only if the register's status tag equals the bus tag. A stale producer's broadcast leaves the register unchanged.
- R9: A station is freed in the cycle its tag is broadcast, and it can be allocated again from the next cycle.
- R10: After reset, all stations are free, nothing is dispatched, every status tag is 0, and register i holds the value ((i+1) << 32) | (7*i + 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Head of the instruction queue is valid |
| issue_op | input | 2 | Opcode; bit 1 selects the station class |
| issue_dst | input | 3 | Destination register |
| issue_src1 | input | 3 | First source register |
| issue_src2 | input | 3 | Second source register |
| issue_ready | output | 1 | A station of the requested class is free |
| disp_valid | output | 1 | A station is handed to the functional units |
| disp_tag | output | 4 | Tag of the dispatched station |
| disp_op | output | 2 | Opcode of the dispatched station |
| disp_vj | output | 64 | First operand value |
| disp_vk | output | 64 | Second operand value |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Result data |
| rd_addr | input | 3 | Register read-port address |
| rd_data | output | 64 | Value of the addressed register |
| rd_tag | output | 4 | Pending producer tag of the addressed register |

## Verification
The outputs follow three timings. `issue_ready` and the source resolution respond within the same cycle as the inputs. A dispatch appears in the cycle after the clock edge that completed the station's operands. A broadcast shows on the register read port one cycle after it is driven. The bench drives every input just after the falling edge and samples 1 ns later, so each sample falls in the cycle the requirement names. A bench model tracks station occupancy, the sequential register values and the expected operands per tag. It also acts as the functional units, returning results after random latencies. This lets every dispatch be compared with its expected operands, and the final register state with a sequential execution.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 2;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [OP_W-1:0]   op_t;

  // class select: high bit of the opcode picks the multiply class
  function automatic logic op_is_mul(op_t op);
    return op[OP_W-1];
  endfunction

  // reset contents of register idx
  function automatic data_t reg_init(int unsigned idx);
    return {32'(idx + 1), 32'(idx * 7 + 3)};
  endfunction

  // a pending tag q is satisfied by a valid broadcast of tag t
  function automatic logic tag_hit(tag_t q, logic v, tag_t t);
    return v && (q != '0) && (q == t);
  endfunction
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter tag_t MY_TAG = tag_t'(1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc,
  input  op_t   a_op,
  input  data_t a_vj,
  input  data_t a_vk,
  input  tag_t  a_qj,
  input  tag_t  a_qk,
  input  logic  cdb_valid,
  input  tag_t  cdb_tag,
  input  data_t cdb_data,
  input  logic  grant,
  output logic  busy,
  output logic  ready,
  output op_t   op,
  output data_t vj,
  output data_t vk
);
  logic exec_q;
  tag_t qj_q, qk_q;
  logic done_hit, hit_j, hit_k;

  assign done_hit = busy && tag_hit(MY_TAG, cdb_valid, cdb_tag);
  assign hit_j    = busy && tag_hit(qj_q, cdb_valid, cdb_tag);
  assign hit_k    = busy && tag_hit(qk_q, cdb_valid, cdb_tag);
  assign ready    = busy && !exec_q && (qj_q == '0) && (qk_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      exec_q <= 1'b0;
      op     <= '0;
      vj     <= '0;
      vk     <= '0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else if (alloc) begin
      busy   <= 1'b1;
      exec_q <= 1'b0;
      op     <= a_op;
      vj     <= a_vj;
      vk     <= a_vk;
      qj_q   <= a_qj;
      qk_q   <= a_qk;
    end else if (done_hit) begin
      busy   <= 1'b0;
      exec_q <= 1'b0;
    end else if (busy) begin
      if (grant) exec_q <= 1'b1;
      if (hit_j) begin
        vj   <= cdb_data;
        qj_q <= '0;
      end
      if (hit_k) begin
        vk   <= cdb_data;
        qk_q <= '0;
      end
    end
  end

  p_grant_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> ready);
  p_no_redispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !ready);
  p_capture_j_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_j && !done_hit) |=> (qj_q == '0) && (vj == $past(cdb_data)));
  p_capture_k_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_k && !done_hit) |=> (qk_q == '0) && (vk == $past(cdb_data)));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> !busy);
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat
  import rs_pkg::*;
#(
  parameter int NREG = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_we,
  input  logic [RW-1:0] iss_dst,
  input  tag_t          iss_tag,
  input  logic [RW-1:0] s1_addr,
  input  logic [RW-1:0] s2_addr,
  output data_t         s1_val,
  output tag_t          s1_tag,
  output data_t         s2_val,
  output tag_t          s2_tag,
  input  logic          cdb_valid,
  input  tag_t          cdb_tag,
  input  data_t         cdb_data,
  input  logic [RW-1:0] rd_addr,
  output data_t         rd_val,
  output tag_t          rd_tag
);
  data_t val_q  [NREG];
  tag_t  stat_q [NREG];

  // resolve a source: register value, same-cycle bus data, or producer tag
  always_comb begin
    s1_tag = tag_hit(stat_q[s1_addr], cdb_valid, cdb_tag) ? '0 : stat_q[s1_addr];
    s2_tag = tag_hit(stat_q[s2_addr], cdb_valid, cdb_tag) ? '0 : stat_q[s2_addr];
    if (stat_q[s1_addr] == '0)                               s1_val = val_q[s1_addr];
    else if (tag_hit(stat_q[s1_addr], cdb_valid, cdb_tag))   s1_val = cdb_data;
    else                                                      s1_val = '0;
    if (stat_q[s2_addr] == '0)                               s2_val = val_q[s2_addr];
    else if (tag_hit(stat_q[s2_addr], cdb_valid, cdb_tag))   s2_val = cdb_data;
    else                                                      s2_val = '0;
  end

  assign rd_val = val_q[rd_addr];
  assign rd_tag = stat_q[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        val_q[i]  <= reg_init(i);
        stat_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (tag_hit(stat_q[i], cdb_valid, cdb_tag)) begin
          val_q[i]  <= cdb_data;
          stat_q[i] <= '0;
        end
        if (iss_we && (iss_dst == RW'(i))) stat_q[i] <= iss_tag;
      end
    end
  end

  p_latest_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_we |=> stat_q[$past(iss_dst)] == $past(iss_tag));

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    p_match_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && (cdb_tag != '0) && (stat_q[g] == cdb_tag) &&
       !(iss_we && (iss_dst == RW'(g))))
      |=> (val_q[g] == $past(cdb_data)) && (stat_q[g] == '0));
    p_stale_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && (stat_q[g] != cdb_tag)) |=> $stable(val_q[g]));
  end
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int NADD = 2,
  parameter int NMUL = 2,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [OP_W-1:0]         issue_op,
  input  logic [$clog2(NREG)-1:0] issue_dst,
  input  logic [$clog2(NREG)-1:0] issue_src1,
  input  logic [$clog2(NREG)-1:0] issue_src2,
  output logic                    issue_ready,
  output logic                    disp_valid,
  output logic [TAG_W-1:0]        disp_tag,
  output logic [OP_W-1:0]         disp_op,
  output logic [DATA_W-1:0]       disp_vj,
  output logic [DATA_W-1:0]       disp_vk,
  input  logic                    cdb_valid,
  input  logic [TAG_W-1:0]        cdb_tag,
  input  logic [DATA_W-1:0]       cdb_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [TAG_W-1:0]        rd_tag
);
  localparam int NST = NADD + NMUL;
  localparam int IW  = (NST > 1) ? $clog2(NST) : 1;

  logic [NST-1:0] st_busy, st_ready, mul_cls, free_req;
  logic [NST-1:0] alloc_gnt, disp_gnt;
  logic [IW-1:0]  alloc_idx, disp_idx;
  logic           alloc_any, issue_fire;
  tag_t           alloc_tag;
  op_t            st_op [NST];
  data_t          st_vj [NST];
  data_t          st_vk [NST];
  data_t          s1_val, s2_val;
  tag_t           s1_tag, s2_tag;

  for (genvar i = 0; i < NST; i++) begin : g_cls
    assign mul_cls[i] = (i >= NADD);
  end

  assign free_req    = ~st_busy & (op_is_mul(issue_op) ? mul_cls : ~mul_cls);
  assign issue_ready = alloc_any;
  assign issue_fire  = issue_valid && alloc_any;
  assign alloc_tag   = tag_t'(alloc_idx) + tag_t'(1);

  rs_pick #(.N(NST), .IW(IW)) u_alloc_pick (
    .req(free_req), .gnt(alloc_gnt), .any(alloc_any), .idx(alloc_idx)
  );

  rs_regstat #(.NREG(NREG)) u_regstat (
    .clk(clk), .rst_n(rst_n),
    .iss_we(issue_fire), .iss_dst(issue_dst), .iss_tag(alloc_tag),
    .s1_addr(issue_src1), .s2_addr(issue_src2),
    .s1_val(s1_val), .s1_tag(s1_tag), .s2_val(s2_val), .s2_tag(s2_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .rd_addr(rd_addr), .rd_val(rd_data), .rd_tag(rd_tag)
  );

  for (genvar i = 0; i < NST; i++) begin : g_st
    rs_station #(.MY_TAG(tag_t'(i + 1))) u_st (
      .clk(clk), .rst_n(rst_n),
      .alloc(issue_fire && alloc_gnt[i]),
      .a_op(issue_op), .a_vj(s1_val), .a_vk(s2_val),
      .a_qj(s1_tag), .a_qk(s2_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .grant(disp_gnt[i]),
      .busy(st_busy[i]), .ready(st_ready[i]),
      .op(st_op[i]), .vj(st_vj[i]), .vk(st_vk[i])
    );
  end

  rs_pick #(.N(NST), .IW(IW)) u_disp_pick (
    .req(st_ready), .gnt(disp_gnt), .any(disp_valid), .idx(disp_idx)
  );

  assign disp_tag = disp_valid ? tag_t'(disp_idx) + tag_t'(1) : '0;
  assign disp_op  = st_op[disp_idx];
  assign disp_vj  = st_vj[disp_idx];
  assign disp_vk  = st_vk[disp_idx];

  p_alloc_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> st_busy[$past(alloc_idx)]);
  p_alloc_was_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !st_busy[alloc_idx]);
  p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ((st_ready & ((NST'(1) << disp_idx) - NST'(1))) == '0));
  p_single_disp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disp_gnt & st_ready) == (disp_valid ? 1 : 0));
endmodule

// File: tb/test_rs_array.sv
`timescale 1ns/1ps
module test_rs_array;
  import rs_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0;
  op_t  issue_op = '0;
  logic [2:0] issue_dst = '0, issue_src1 = '0, issue_src2 = '0, rd_addr = '0;
  logic issue_ready, disp_valid, cdb_valid = 1'b0;
  tag_t disp_tag, cdb_tag = '0, rd_tag;
  op_t  disp_op;
  data_t disp_vj, disp_vk, cdb_data = '0, rd_data;

  rs_array i_rs_array (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
    .issue_src1(issue_src1), .issue_src2(issue_src2), .issue_ready(issue_ready),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_vj(disp_vj), .disp_vk(disp_vk),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic s_rdy, s_acc, s_dv;
  tag_t s_dt;
  op_t  s_dop;
  data_t s_dj, s_dk;
  data_t g [8];
  logic bbusy [16], pend [16], edisp [16];
  data_t res [16], ej [16], ek [16];
  op_t  eop [16];
  int   due [16];

  function automatic data_t ini(int i);
    return (64'(i + 1) << 32) | 64'(i * 7 + 3);
  endfunction

  function automatic data_t fu(op_t o, data_t a, data_t b);
    case (o)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return a ^ (b << 1);
    endcase
  endfunction

  function automatic int pred_tag(op_t o);
    int lo = o[1] ? 3 : 1;
    for (int t = lo; t < lo + 2; t++) if (!bbusy[t]) return t;
    return 0;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input op_t o, input logic [2:0] d, input logic [2:0] a,
                     input logic [2:0] b, input logic c, input tag_t t, input data_t x);
    @(negedge clk);
    issue_valid = v; issue_op = o; issue_dst = d; issue_src1 = a; issue_src2 = b;
    cdb_valid = c; cdb_tag = t; cdb_data = x;
    #1;
    s_rdy = issue_ready; s_acc = v && issue_ready; s_dv = disp_valid;
    s_dt = disp_tag; s_dop = disp_op; s_dj = disp_vj; s_dk = disp_vk;
  endtask

  task automatic rdchk(input logic [2:0] r, input data_t ev, input tag_t et, input string req);
    rd_addr = r;
    #0.2;
    chk(rd_data == ev, req, rd_data, ev);
    chk(rd_tag == et, req, 64'(rd_tag), 64'(et));
  endtask

  task automatic dchk(input tag_t t, input op_t o, input data_t a, input data_t b, input string req);
    chk(s_dv == 1'b1, req, 64'(s_dv), 64'd1);
    chk(s_dt == t, req, 64'(s_dt), 64'(t));
    chk(s_dop == o, req, 64'(s_dop), 64'(o));
    chk(s_dj == a, req, s_dj, a);
    chk(s_dk == b, req, s_dk, b);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R5 watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    data_t x, y, z, w, p, q;
    int issued = 0, cycn = 0, ptag;
    logic have = 0, iv, cv;
    op_t ro;
    logic [2:0] rdst, rs1, rs2;
    tag_t ct;
    data_t cd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) g[i] = ini(i);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10 reset state
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    chk(s_rdy, "R10 ready after reset", 64'(s_rdy), 1);
    chk(!s_dv, "R10 no dispatch after reset", 64'(s_dv), 0);
    for (int i = 0; i < 8; i++) rdchk(3'(i), ini(i), 0, "R10 register reset");

    // directed: dependency chain, stall, bypass, priority
    x = fu(2, g[2], g[3]);
    cyc(1, 2'd2, 1, 2, 3, 0, 0, 0);
    chk(s_acc, "R1 mul accepted", 64'(s_acc), 1);
    cyc(1, 2'd0, 4, 1, 2, 0, 0, 0);
    chk(s_acc, "R1 add accepted", 64'(s_acc), 1);
    dchk(3, 2, g[2], g[3], "R2 R3 first mul station from registers");
    rdchk(1, g[1], 3, "R7 status tag recorded");
    cyc(1, 2'd1, 5, 1, 1, 0, 0, 0);
    chk(!s_dv, "R5 waiting stations not dispatched", 64'(s_dv), 0);
    cyc(1, 2'd0, 6, 0, 0, 0, 0, 0);
    chk(!s_acc, "R1 add stalls when add class full", 64'(s_acc), 0);
    cyc(0, 2'd2, 0, 0, 0, 0, 0, 0);
    chk(s_rdy, "R1 mul class still free", 64'(s_rdy), 1);
    y = fu(0, x, g[2]);
    cyc(1, 2'd2, 7, 1, 4, 1, 3, x);
    chk(s_acc, "R3 issue during broadcast", 64'(s_acc), 1);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    dchk(1, 0, x, g[2], "R6 R4 lowest ready first");
    rdchk(1, x, 0, "R8 register written on matching tag");
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    dchk(2, 1, x, x, "R6 second ready station next");
    cyc(0, 2'd0, 0, 0, 0, 1, 1, y);
    chk(!s_dv, "R5 station waits on second operand", 64'(s_dv), 0);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    dchk(4, 2, x, y, "R3 R4 same-cycle bypass operand");
    chk(s_rdy, "R9 freed station allocatable", 64'(s_rdy), 1);
    z = fu(1, x, x);
    w = fu(2, x, y);
    cyc(0, 2'd0, 0, 0, 0, 1, 2, z);
    cyc(0, 2'd0, 0, 0, 0, 1, 4, w);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    g[1] = x; g[4] = y; g[5] = z; g[7] = w;
    rdchk(4, y, 0, "R8 result r4");
    rdchk(5, z, 0, "R8 result r5");
    rdchk(7, w, 0, "R8 result r7");
    rdchk(6, g[6], 0, "R1 stalled instruction left r6 untouched");

    // directed: two writers of one register, stale broadcast ignored
    p = fu(3, g[0], g[0]);
    q = fu(2, g[3], g[3]);
    cyc(1, 2'd2, 2, 3, 3, 0, 0, 0);
    cyc(1, 2'd3, 2, 0, 0, 0, 0, 0);
    chk(s_acc, "R2 second mul station", 64'(s_acc), 1);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    dchk(4, 3, g[0], g[0], "R5 second writer dispatched");
    rdchk(2, g[2], 4, "R7 latest writer tag");
    cyc(0, 2'd0, 0, 0, 0, 1, 4, p);
    cyc(0, 2'd0, 0, 0, 0, 1, 3, q);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    g[2] = p;
    rdchk(2, p, 0, "R8 stale broadcast ignored");

    // random phase with bench functional-unit model
    for (int t = 0; t < 16; t++) begin
      bbusy[t] = 0; pend[t] = 0; edisp[t] = 0; due[t] = 0;
      res[t] = '0; ej[t] = '0; ek[t] = '0; eop[t] = '0;
    end
    ro = '0; rdst = '0; rs1 = '0; rs2 = '0;
    while ((issued < 300 || bbusy[1] || bbusy[2] || bbusy[3] || bbusy[4]) && cycn < 20000) begin
      cv = 0; ct = '0; cd = '0;
      for (int t = 1; t <= 4; t++)
        if (!cv && pend[t] && due[t] <= cycn) begin cv = 1; ct = tag_t'(t); cd = res[t]; end
      if (!have && issued < 300) begin
        ro = op_t'($urandom % 4); rdst = 3'($urandom % 8);
        rs1 = 3'($urandom % 8); rs2 = 3'($urandom % 8); have = 1;
      end
      iv = have && ($urandom % 5 != 0);
      cyc(iv, ro, rdst, rs1, rs2, cv, ct, cd);
      ptag = pred_tag(ro);
      chk(s_rdy == (ptag != 0), "R1 ready matches free class", 64'(s_rdy), 64'(ptag != 0));
      if (s_acc) begin
        eop[ptag] = ro; ej[ptag] = g[rs1]; ek[ptag] = g[rs2];
        edisp[ptag] = 0; bbusy[ptag] = 1;
        g[rdst] = fu(ro, g[rs1], g[rs2]);
        issued++; have = 0;
      end
      if (s_dv) begin
        chk(bbusy[s_dt] && !edisp[s_dt], "R5 dispatch of live station", 64'(s_dt), 64'(s_dt));
        chk(s_dop == eop[s_dt], "R2 dispatched opcode", 64'(s_dop), 64'(eop[s_dt]));
        chk(s_dj == ej[s_dt], "R3 R4 dispatched first operand", s_dj, ej[s_dt]);
        chk(s_dk == ek[s_dt], "R3 R4 dispatched second operand", s_dk, ek[s_dt]);
        edisp[s_dt] = 1; pend[s_dt] = 1;
        res[s_dt] = fu(eop[s_dt], ej[s_dt], ek[s_dt]);
        due[s_dt] = cycn + 1 + int'($urandom % 4);
      end
      if (cv) begin pend[ct] = 0; bbusy[ct] = 0; end
      cycn++;
    end
    chk(issued == 300, "R9 all instructions issued", 64'(issued), 300);
    cyc(0, 2'd0, 0, 0, 0, 0, 0, 0);
    chk(!s_dv, "R5 nothing left to dispatch", 64'(s_dv), 0);
    for (int i = 0; i < 8; i++) rdchk(3'(i), g[i], 0, "R8 final register state");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule